// File: doc/BRIEF.md
# Atomic Multi-Byte Current Result Registers

This block presents the results of a current-measurement converter to an 8-bit processor bus. Two result groups are kept side by side. The instantaneous group takes a 13-bit signed sample. It widens the sample to 16 bits and shows it as two readable bytes. The accumulated group takes an 18-bit signed sum. It widens the sum to 32 bits and shows it as four readable bytes. Each group loads a new value when its conversion-done strobe pulses.

Software reads a group one byte at a time, starting with the least significant byte. A read of the lowest byte freezes the whole group. A read of the highest byte releases it. Every byte seen between those two reads belongs to the same conversion. A conversion that finishes while a group is frozen waits in a one-entry holding slot and becomes visible once the group is released. If that slot is overwritten before it is consumed, a sticky overrun flag is raised for the group.

Top module: `adc_result_regs`

## Requirements
- R1: After synchronous reset, every result byte reads 0x00 and both overrun flags are 0.
- R2: The instantaneous value is laid out as follows. The raw sample sits in bits 12:0. Bits 15:13 repeat raw bit 12. Byte address 0xE8 returns bits 7:0 and 0xE9 returns bits 15:8.
- R3: The accumulated value is laid out as follows. The raw sum sits in bits 17:0. Bits 31:18 repeat raw bit 17. Byte addresses 0xE0, 0xE1, 0xE2 and 0xE3 return bits 7:0, 15:8, 23:16 and 31:24.
- R4: A group that is not frozen loads the widened raw value on the clock edge that samples its done strobe. A read returns the registered value combinationally in the cycle it is issued, so a read in the same cycle as the strobe still returns the old value.
- R5: A read of 0xE8 freezes the instantaneous value. The value stays frozen until a read of 0xE9.
- R6: A read of 0xE0 freezes the accumulated value, and only a read of 0xE3 releases it. Reads of 0xE1 or 0xE2 neither freeze nor release the group.
- R7: A done strobe that arrives while a group is frozen stores the result in a pending slot. The pending result becomes visible on the clock edge that samples the highest-byte read.
- R8: A group's overrun flag is set in two cases: a done strobe arrives while that group's pending slot is full, or a done strobe arrives in the release cycle while a result is still pending. The newer result wins. The flag stays at 1 until reset.
- R9: rd_data is 0x00 when rd_en is low or when rd_addr is outside 0xE0 to 0xE3 and 0xE8 to 0xE9.
- R10: A done strobe in the same cycle as a lowest-byte read goes to the pending slot, so the bytes read afterwards still come from the old conversion.
- R11: The two groups are independent. A freeze or overrun in one group does not change the other group's updates or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_done | input | 1 | Instantaneous conversion complete strobe |
| inst_raw | input | 13 | Instantaneous signed raw result |
| acc_done | input | 1 | Accumulated conversion complete strobe |
| acc_raw | input | 18 | Accumulated signed raw result |
| rd_en | input | 1 | Bus read strobe, one cycle per byte |
| rd_addr | input | 8 | Bus byte address |
| rd_data | output | 8 | Read data, combinational |
| inst_overrun | output | 1 | Sticky overrun flag, instantaneous group |
| acc_overrun | output | 1 | Sticky overrun flag, accumulated group |

## Verification
The assertions check several properties on every cycle. A frozen group's visible value does not move until the highest-byte read. A lowest-byte read always leaves the group frozen, and a highest-byte read always clears both the freeze and the pending slot. An unfrozen done strobe loads exactly the widened sample. The sign-copy bits are always uniform. The overrun flags never fall, and an idle bus returns zero. Other behaviours need the bench's read sequences. These include: byte ordering at each address; middle accumulated reads leaving the freeze alone; which conversion becomes visible after a release; a done in the same cycle as the low-byte read; and one group's freeze leaving the other group free.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 8;
    localparam int LANE_W     = 2;
    localparam int MAX_BYTES  = 1 << LANE_W;

    localparam int INST_RAW_W = 13;
    localparam int INST_BYTES = 2;
    localparam int ACC_RAW_W  = 18;
    localparam int ACC_BYTES  = 4;

    localparam logic [ADDR_W-1:0] INST_BASE = 8'hE8;
    localparam logic [ADDR_W-1:0] ACC_BASE  = 8'hE0;

    // One group's view of the current bus cycle
    typedef struct packed {
        logic              hit;
        logic [LANE_W-1:0] lane;
        logic              first;
        logic              last;
    } lane_sel_t;

    function automatic lane_sel_t window_decode(
        input logic              en,
        input logic [ADDR_W-1:0] addr,
        input logic [ADDR_W-1:0] base,
        input int                nbytes
    );
        lane_sel_t         s;
        logic [ADDR_W-1:0] off;
        off     = addr - base;
        s.hit   = en && (off < ADDR_W'(nbytes));
        s.lane  = off[LANE_W-1:0];
        s.first = s.hit && (off == '0);
        s.last  = s.hit && (off == ADDR_W'(nbytes - 1));
        return s;
    endfunction

endpackage

// File: rtl/adc_addr_decode.sv
module adc_addr_decode
    import adc_regs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] INST_ADDR = INST_BASE,
    parameter int                INST_N    = INST_BYTES,
    parameter logic [ADDR_W-1:0] ACC_ADDR  = ACC_BASE,
    parameter int                ACC_N     = ACC_BYTES
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output lane_sel_t         inst_sel,
    output lane_sel_t         acc_sel
);

    generate
        if (INST_N < 1 || INST_N > MAX_BYTES || ACC_N < 1 || ACC_N > MAX_BYTES) begin : g_bad
            initial $error("byte count out of lane range");
        end
    endgenerate

    always_comb begin
        inst_sel = window_decode(rd_en, rd_addr, INST_ADDR, INST_N);
        acc_sel  = window_decode(rd_en, rd_addr, ACC_ADDR, ACC_N);
    end

    // R9: the windows never overlap, so at most one group is addressed
    always_comb begin
        a_r9_one_window: assert ($onehot0({inst_sel.hit, acc_sel.hit}));
    end

endmodule

// File: rtl/adc_result_group.sv
module adc_result_group
    import adc_regs_pkg::*;
#(
    parameter int RAW_W  = INST_RAW_W,
    parameter int NBYTES = INST_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [RAW_W-1:0]  raw,
    input  lane_sel_t         sel,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              overrun
);

    localparam int REG_W = NBYTES * BYTE_W;
    localparam int EXT_W = REG_W - RAW_W;

    typedef struct packed {
        logic             frozen;
        logic             pend_valid;
        logic [REG_W-1:0] pend;
        logic [REG_W-1:0] vis;
        logic             ovr;
    } grp_state_t;

    grp_state_t       st;
    logic [REG_W-1:0] ext;
    logic             rd_first;
    logic             rd_last;
    logic             hold;

    generate
        if (EXT_W > 0) begin : g_ext
            assign ext = {{EXT_W{raw[RAW_W-1]}}, raw};
        end else begin : g_noext
            assign ext = raw[REG_W-1:0];
        end
    endgenerate

    assign rd_first = sel.first;
    assign rd_last  = sel.last;
    // a lowest-byte read protects the value already in its own cycle
    assign hold     = st.frozen | rd_first;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (rd_last) begin
            st.frozen     <= 1'b0;
            st.pend_valid <= 1'b0;
            if (done) begin
                st.vis <= ext;
                if (st.pend_valid) st.ovr <= 1'b1;
            end else if (st.pend_valid) begin
                st.vis <= st.pend;
            end
        end else if (hold) begin
            if (rd_first) st.frozen <= 1'b1;
            if (done) begin
                st.pend       <= ext;
                st.pend_valid <= 1'b1;
                if (st.pend_valid) st.ovr <= 1'b1;
            end
        end else if (done) begin
            st.vis <= ext;
        end
    end

    logic [BYTE_W-1:0] lanes [NBYTES];

    generate
        for (genvar g = 0; g < NBYTES; g++) begin : g_lane
            assign lanes[g] = st.vis[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (sel.hit && sel.lane == LANE_W'(i)) rd_byte = lanes[i];
        end
    end

    assign overrun = st.ovr;

    // R5 / R6: a frozen group keeps its visible value until its top byte is read
    a_r5_frozen_stable: assert property (@(posedge clk) disable iff (rst)
        st.frozen && !rd_last |=> $stable(st.vis));

    // R4: an unfrozen done loads the widened sample on the next edge
    a_r4_unfrozen_load: assert property (@(posedge clk) disable iff (rst)
        !st.frozen && !rd_first && !rd_last && done |=> st.vis == $past(ext));

    // R10 / R6: a lowest-byte read always leaves the group frozen
    a_r10_first_freezes: assert property (@(posedge clk) disable iff (rst)
        rd_first |=> st.frozen);

    // R7: the highest-byte read clears both freeze and pending slot
    a_r7_release_clears: assert property (@(posedge clk) disable iff (rst)
        rd_last |=> !st.frozen && !st.pend_valid);

    // R8: overrun never falls outside reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        st.ovr |=> st.ovr);

    // R2 / R3: the sign-copy bits are uniform
    a_r2_r3_sign_copy: assert property (@(posedge clk) disable iff (rst)
        (st.vis[REG_W-1:RAW_W-1] == '0) || (st.vis[REG_W-1:RAW_W-1] == '1));

endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
    import adc_regs_pkg::*;
#(
    parameter int                I_RAW_W  = INST_RAW_W,
    parameter int                I_BYTES  = INST_BYTES,
    parameter int                A_RAW_W  = ACC_RAW_W,
    parameter int                A_BYTES  = ACC_BYTES,
    parameter logic [ADDR_W-1:0] I_ADDR   = INST_BASE,
    parameter logic [ADDR_W-1:0] A_ADDR   = ACC_BASE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               inst_done,
    input  logic [I_RAW_W-1:0] inst_raw,
    input  logic               acc_done,
    input  logic [A_RAW_W-1:0] acc_raw,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0]  rd_data,
    output logic               inst_overrun,
    output logic               acc_overrun
);

    lane_sel_t         inst_sel;
    lane_sel_t         acc_sel;
    logic [BYTE_W-1:0] inst_byte;
    logic [BYTE_W-1:0] acc_byte;

    adc_addr_decode #(
        .INST_ADDR (I_ADDR),
        .INST_N    (I_BYTES),
        .ACC_ADDR  (A_ADDR),
        .ACC_N     (A_BYTES)
    ) u_decode (
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .inst_sel (inst_sel),
        .acc_sel  (acc_sel)
    );

    adc_result_group #(
        .RAW_W  (I_RAW_W),
        .NBYTES (I_BYTES)
    ) u_inst (
        .clk     (clk),
        .rst     (rst),
        .done    (inst_done),
        .raw     (inst_raw),
        .sel     (inst_sel),
        .rd_byte (inst_byte),
        .overrun (inst_overrun)
    );

    adc_result_group #(
        .RAW_W  (A_RAW_W),
        .NBYTES (A_BYTES)
    ) u_acc (
        .clk     (clk),
        .rst     (rst),
        .done    (acc_done),
        .raw     (acc_raw),
        .sel     (acc_sel),
        .rd_byte (acc_byte),
        .overrun (acc_overrun)
    );

    // unaddressed group drives zero, so OR is a plain mux
    assign rd_data = inst_byte | acc_byte;

    // R9: an idle bus returns zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rd_data == '0);

endmodule

// File: tb/adc_result_regs_bench.sv
module adc_result_regs_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inst_done = 1'b0;
    logic [12:0] inst_raw = '0;
    logic        acc_done = 1'b0;
    logic [17:0] acc_raw = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        inst_overrun;
    logic        acc_overrun;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_result_regs u_adc_result_regs (
        .clk          (clk),
        .rst          (rst),
        .inst_done    (inst_done),
        .inst_raw     (inst_raw),
        .acc_done     (acc_done),
        .acc_raw      (acc_raw),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .inst_overrun (inst_overrun),
        .acc_overrun  (acc_overrun)
    );

    typedef struct {
        logic [7:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t exp_q[$];

    // expected widened values, from R2 / R3
    function automatic logic [15:0] wide13(input logic [12:0] r);
        return {{3{r[12]}}, r};
    endfunction

    function automatic logic [31:0] wide18(input logic [17:0] r);
        return {{14{r[17]}}, r};
    endfunction

    // driver: one bus cycle; pushes the expected byte when reading
    task automatic step(input bit r, input logic [7:0] a, input logic [7:0] e, input string tag,
                        input bit id, input logic [12:0] ir, input bit ad, input logic [17:0] ar);
        item_t it;
        @(negedge clk);
        rd_en     = r;
        rd_addr   = a;
        inst_done = id;
        inst_raw  = ir;
        acc_done  = ad;
        acc_raw   = ar;
        if (r) begin
            it.addr = a; it.exp = e; it.tag = tag;
            exp_q.push_back(it);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        step(1'b1, a, e, tag, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic idle();
        step(1'b0, 8'h00, 8'h00, "", 1'b0, '0, 1'b0, '0);
    endtask

    task automatic flag_check(input logic act, input logic exp, input string tag);
        #2;
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s flag actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic read_inst(input logic [15:0] v, input string tag);
        rd(8'hE8, v[7:0], tag);
        rd(8'hE9, v[15:8], tag);
    endtask

    task automatic read_acc(input logic [31:0] v, input string tag);
        rd(8'hE0, v[7:0], tag);
        rd(8'hE1, v[15:8], tag);
        rd(8'hE2, v[23:16], tag);
        rd(8'hE3, v[31:24], tag);
    endtask

    // monitor: compares each read shortly after it is driven
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_en) begin
                item_t it;
                it = exp_q.pop_front();
                checks++;
                if (rd_data !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr %h actual %h expected %h", it.tag, it.addr, rd_data, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        read_inst(16'h0000, "R1");
        read_acc(32'h0000_0000, "R1");
        idle(); flag_check(inst_overrun, 1'b0, "R1");
        flag_check(acc_overrun, 1'b0, "R1");

        // R4 + R2: same-cycle read sees old value; next cycle new
        step(1'b1, 8'hE9, 8'h00, "R4", 1'b1, 13'h1ABC, 1'b0, '0);
        rd(8'hE9, wide13(13'h1ABC) >> 8, "R4");
        read_inst(16'hFABC, "R2");
        step(1'b0, 8'h00, 8'h00, "", 1'b1, 13'h0123, 1'b0, '0);
        read_inst(16'h0123, "R2");

        // R3: negative and positive accumulated values
        step(1'b1, 8'hE3, 8'h00, "R4", 1'b0, '0, 1'b1, 18'h2ABCD);
        read_acc(32'hFFFE_ABCD, "R3");
        step(1'b0, 8'h00, 8'h00, "", 1'b0, '0, 1'b1, 18'h1F00F);
        read_acc(wide18(18'h1F00F), "R3");

        // R5 + R7: instantaneous freeze, pending moves in on release
        rd(8'hE8, 8'h23, "R5");
        step(1'b0, 8'h00, 8'h00, "", 1'b1, 13'h0FFF, 1'b0, '0);
        rd(8'hE9, 8'h01, "R5");
        read_inst(16'h0FFF, "R7");

        // R6: middle reads neither freeze nor release
        rd(8'hE0, 8'h0F, "R6");
        step(1'b1, 8'hE1, 8'hF0, "R6", 1'b0, '0, 1'b1, 18'h20000);
        rd(8'hE2, 8'h01, "R6");
        rd(8'hE1, 8'hF0, "R6");
        rd(8'hE3, 8'h00, "R6");
        read_acc(32'hFFFE_0000, "R7");
        step(1'b1, 8'hE1, 8'h00, "R6", 1'b0, '0, 1'b1, 18'h00005);
        read_acc(32'h0000_0005, "R6");

        // R8 + R11: two dones while frozen set only the instantaneous flag
        rd(8'hE8, 8'hFF, "R8");
        step(1'b0, 8'h00, 8'h00, "", 1'b1, 13'h0001, 1'b0, '0);
        step(1'b0, 8'h00, 8'h00, "", 1'b1, 13'h1000, 1'b0, '0);
        idle(); flag_check(inst_overrun, 1'b1, "R8");
        flag_check(acc_overrun, 1'b0, "R11");
        rd(8'hE9, 8'h0F, "R8");
        read_inst(16'hF000, "R8");
        idle(); flag_check(inst_overrun, 1'b1, "R8");

        // R10: done in the same cycle as the low-byte read
        step(1'b1, 8'hE0, 8'h05, "R10", 1'b0, '0, 1'b1, 18'h3FFFF);
        rd(8'hE1, 8'h00, "R10");
        rd(8'hE2, 8'h00, "R10");
        rd(8'hE3, 8'h00, "R10");
        read_acc(32'hFFFF_FFFF, "R10");
        idle(); flag_check(acc_overrun, 1'b0, "R10");

        // R11: accumulated group updates while instantaneous is frozen
        rd(8'hE8, 8'h00, "R11");
        step(1'b0, 8'h00, 8'h00, "", 1'b0, '0, 1'b1, 18'h00042);
        read_acc(32'h0000_0042, "R11");
        rd(8'hE9, 8'hF0, "R11");

        // R9: unmapped addresses and idle bus
        rd(8'hE4, 8'h00, "R9");
        rd(8'hEA, 8'h00, "R9");
        rd(8'h00, 8'h00, "R9");
        step(1'b0, 8'hE8, 8'h00, "", 1'b0, '0, 1'b0, '0);
        #1;
        checks++;
        if (rd_data !== 8'h00) begin
            errors++;
            $display("FAIL R9 idle read actual %h expected 00", rd_data);
        end
        idle();
        idle();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule